// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven station manager for the two-wire PHY management bus. It generates the management clock from the system clock, serializes 64-bit management frames onto the data line, releases the line for the turnaround of read frames and captures the 16-bit value returned by the PHY. Both the original short-address framing (Clause 22) and the indirect framing with separate address cycles (Clause 45) are produced.

Software reaches the block through four 32-bit word registers. Frames are launched as a side effect of register writes: writing the data word starts a write frame, writing the address word in Clause 45 mode starts an address frame, and writing the control word with its read bit set starts a read frame. Software then polls a busy flag. After a read it checks an error flag before taking the captured value from the data word.

Top module: `mdio_master`

## Requirements
- R1: After reset the configuration word at offset 0x0 reads 0x00008100 (busy 0, error 0, half-divider 129, Clause 22, rising-edge output), the other three words read 0, MDC is low and the data line is not driven.
- R2: A started frame sets the busy flag (bit 0 of offset 0x0) from the clock after the accepting write until its end. Every frame spans exactly 64 MDC rising edges, and the line is driven only while busy, beginning with a driven 1.
- R3: With configuration bit 6 clear, a write to offset 0x8 sends 32 ones, start 01, opcode 01, PHY address = control bits 9:5, register address = control bits 4:0, turnaround 10, then data bits 15:0, most significant bit first. The written value reads back from offset 0x8.
- R4: With bit 6 clear, a write to offset 0x4 with bit 15 set sends start 01, opcode 10 and the two address fields from that write. The master releases the line from bit 46 on. The 16 bits the PHY returns after the turnaround read back from offset 0x8.
- R5: With bit 6 set, a write to offset 0xC sends start 00, opcode 00, the port address, the device address from control bits 4:0, turnaround 10 and the written 16-bit value. With bit 6 clear, the same write only stores the value, and no frame starts.
- R6: With bit 6 set, a data write sends start 00 and opcode 01, and a read request sends start 00 and opcode 11 and captures the returned data.
- R7: If the line is high at the second turnaround bit of a read, bit 1 of offset 0x0 is set and offset 0x8 reads 0xFFFF. The flag stays set through later non-read frames and clears when the next read starts.
- R8: MDC is low while idle. During a frame, each MDC phase lasts N system clocks, where N is configuration bits 15:8, and 0 counts as 1.
- R9: With configuration bit 23 clear, the output data changes only on clocks where MDC rises. With it set, the output data changes only where MDC falls.
- R10: Register writes that arrive while busy is set change no register and start no frame.
- R11: Configuration bits 6, 15:8 and 23 and control bits 15 and 9:0 read back as written. A control write with bit 15 clear starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe |
| host_wr | input | 1 | Access is a write when high |
| host_addr | input | 4 | Byte offset of the register word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the word selected by host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Resolved data line level |

## Verification
The hardest situations to reach are the read outcomes that hinge on the turnaround bit. One is a missing responder that leaves the pulled-up line high. Another is the sticky error that must survive a later write frame and then clear at the instant the next read starts. The bench models a PHY that samples the line on each MDC rise and can be told to answer or stay silent. It chains a silent read, a write frame and an answered read, and reads the status word while that last read is still in flight. Writes issued back-to-back behind a running frame exercise the lock-out, and both output-edge modes are run with an edge monitor on the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS   = 32;
  localparam int FIELD_W    = 5;
  localparam int DATA_BITS  = 16;
  localparam int FRAME_BITS = PRE_BITS + 4 + 2 * FIELD_W + 2 + DATA_BITS;

  // word select (host_addr[3:2])
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CTL  = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_ADDR = 2'd3;

  // configuration word bit positions
  localparam int CFG_BUSY   = 0;
  localparam int CFG_ERR    = 1;
  localparam int CFG_C45    = 6;
  localparam int CFG_DIV_LO = 8;
  localparam int CFG_NEG    = 23;
  localparam int CTL_READ   = 15;

  typedef enum logic [1:0] {
    FR_ADDR  = 2'd0,
    FR_WRITE = 2'd1,
    FR_READ  = 2'd2
  } frame_kind_t;

  function automatic logic [FRAME_BITS-1:0] make_frame(
    input logic                 c45,
    input frame_kind_t          kind,
    input logic [FIELD_W-1:0]   pa,
    input logic [FIELD_W-1:0]   ra,
    input logic [DATA_BITS-1:0] payload
  );
    logic [1:0] st;
    logic [1:0] op;
    logic [1:0] ta;
    st = c45 ? 2'b00 : 2'b01;
    ta = (kind == FR_READ) ? 2'b11 : 2'b10;
    case (kind)
      FR_ADDR: op = 2'b00;
      FR_READ: op = c45 ? 2'b11 : 2'b10;
      default: op = 2'b01;
    endcase
    return {{PRE_BITS{1'b1}}, st, op, pa, ra, ta, payload};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             mdc,
  output logic             rise_ev,
  output logic             fall_ev
);

  logic [DIV_W-1:0] cnt_q, cnt_d, lim;
  logic             mdc_q, mdc_d, tick;

  always_comb begin
    lim   = (half == '0) ? DIV_W'(1) : half;
    tick  = run && (cnt_q == lim - DIV_W'(1));
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc     = mdc_q;
  assign rise_ev = tick & ~mdc_q;
  assign fall_ev = tick &  mdc_q;

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_read,
  input  logic [FRAME_BITS-1:0] start_frame,
  input  logic                  neg_mode,
  input  logic                  rise_ev,
  input  logic                  fall_ev,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  rd_done,
  output logic                  rd_err,
  output logic [DATA_BITS-1:0]  rd_data
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DFIRST = CNT_W'(FRAME_BITS - DATA_BITS);
  localparam logic [CNT_W-1:0] TA2    = CNT_W'(FRAME_BITS - DATA_BITS - 1);
  localparam logic [CNT_W-1:0] REL    = CNT_W'(FRAME_BITS - DATA_BITS - 2);

  logic                  busy_q, busy_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]      slot_q, slot_d;
  logic [CNT_W-1:0]      rises_q, rises_d;
  logic                  rd_q, rd_d;
  logic                  tabad_q, tabad_d;
  logic [DATA_BITS-1:0]  cap_q, cap_d;
  logic                  launch, done_ev;

  assign launch  = neg_mode ? fall_ev : rise_ev;
  assign done_ev = busy_q && fall_ev && (rises_q == LAST);

  always_comb begin
    busy_d  = busy_q;
    sr_d    = sr_q;
    slot_d  = slot_q;
    rises_d = rises_q;
    rd_d    = rd_q;
    tabad_d = tabad_q;
    cap_d   = cap_q;
    if (start) begin
      busy_d  = 1'b1;
      sr_d    = start_frame;
      slot_d  = '0;
      rises_d = '0;
      rd_d    = start_read;
      tabad_d = 1'b0;
    end else if (busy_q) begin
      if (rise_ev) begin
        rises_d = rises_q + CNT_W'(1);
        if (rises_q == TA2 && mdio_i)
          tabad_d = 1'b1;
        if (rises_q >= DFIRST && rises_q < LAST)
          cap_d = {cap_q[DATA_BITS-2:0], mdio_i};
      end
      if (done_ev) begin
        busy_d = 1'b0;
      end else if (launch) begin
        sr_d   = {sr_q[FRAME_BITS-2:0], 1'b0};
        slot_d = slot_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      sr_q    <= '0;
      slot_q  <= '0;
      rises_q <= '0;
      rd_q    <= 1'b0;
      tabad_q <= 1'b0;
      cap_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      sr_q    <= sr_d;
      slot_q  <= slot_d;
      rises_q <= rises_d;
      rd_q    <= rd_d;
      tabad_q <= tabad_d;
      cap_q   <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sr_q[FRAME_BITS-1];
  assign mdio_oe = busy_q && (slot_q < LAST) && !(rd_q && slot_q >= REL);
  assign rd_done = done_ev && rd_q;
  assign rd_err  = tabad_q;
  assign rd_data = cap_q;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(129)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_req,
  input  logic                  host_wr,
  input  logic [3:0]            host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  input  logic                  busy,
  input  logic                  rd_done,
  input  logic                  rd_err_in,
  input  logic [DATA_BITS-1:0]  rd_cap,
  output logic                  start,
  output logic                  start_read,
  output logic [FRAME_BITS-1:0] start_frame,
  output logic                  cfg_neg,
  output logic [DIV_W-1:0]      cfg_div
);

  logic                 c45_q, c45_d;
  logic                 neg_q, neg_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic                 ctlrd_q, ctlrd_d;
  logic [FIELD_W-1:0]   pa_q, pa_d, ra_q, ra_d;
  logic [DATA_BITS-1:0] data_q, data_d, addr_q, addr_d;
  logic                 err_q, err_d;
  logic                 acc;
  logic [1:0]           sel;
  frame_kind_t          kind;
  logic [FIELD_W-1:0]   fr_pa, fr_ra;
  logic [DATA_BITS-1:0] payload;
  logic                 unused_bits;

  assign acc = host_req && host_wr && !busy;
  assign sel = host_addr[3:2];
  assign unused_bits = ^{host_wdata[31:24], host_wdata[22:16], host_addr[1:0]};

  // frame launch decode
  always_comb begin
    start   = 1'b0;
    kind    = FR_WRITE;
    fr_pa   = pa_q;
    fr_ra   = ra_q;
    payload = host_wdata[DATA_BITS-1:0];
    if (acc) begin
      case (sel)
        SEL_DATA: start = 1'b1;
        SEL_ADDR: begin
          start = c45_q;
          kind  = FR_ADDR;
        end
        SEL_CTL: begin
          start   = host_wdata[CTL_READ];
          kind    = FR_READ;
          fr_pa   = host_wdata[2*FIELD_W-1:FIELD_W];
          fr_ra   = host_wdata[FIELD_W-1:0];
          payload = '1;
        end
        default: start = 1'b0;
      endcase
    end
    start_read  = start && (kind == FR_READ);
    start_frame = make_frame(c45_q, kind, fr_pa, fr_ra, payload);
  end

  // register next state
  always_comb begin
    c45_d   = c45_q;
    neg_d   = neg_q;
    div_d   = div_q;
    ctlrd_d = ctlrd_q;
    pa_d    = pa_q;
    ra_d    = ra_q;
    data_d  = data_q;
    addr_d  = addr_q;
    err_d   = err_q;
    if (acc) begin
      case (sel)
        SEL_CFG: begin
          c45_d = host_wdata[CFG_C45];
          neg_d = host_wdata[CFG_NEG];
          div_d = host_wdata[CFG_DIV_LO +: DIV_W];
        end
        SEL_CTL: begin
          ctlrd_d = host_wdata[CTL_READ];
          pa_d    = host_wdata[2*FIELD_W-1:FIELD_W];
          ra_d    = host_wdata[FIELD_W-1:0];
        end
        SEL_DATA: data_d = host_wdata[DATA_BITS-1:0];
        default:  addr_d = host_wdata[DATA_BITS-1:0];
      endcase
    end
    if (start_read) begin
      err_d = 1'b0;
    end else if (rd_done) begin
      err_d  = rd_err_in;
      data_d = rd_err_in ? '1 : rd_cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q   <= 1'b0;
      neg_q   <= 1'b0;
      div_q   <= DIV_RESET;
      ctlrd_q <= 1'b0;
      pa_q    <= '0;
      ra_q    <= '0;
      data_q  <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      c45_q   <= c45_d;
      neg_q   <= neg_d;
      div_q   <= div_d;
      ctlrd_q <= ctlrd_d;
      pa_q    <= pa_d;
      ra_q    <= ra_d;
      data_q  <= data_d;
      addr_q  <= addr_d;
      err_q   <= err_d;
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    case (sel)
      SEL_CFG: begin
        host_rdata[CFG_BUSY]                = busy;
        host_rdata[CFG_ERR]                 = err_q;
        host_rdata[CFG_C45]                 = c45_q;
        host_rdata[CFG_DIV_LO +: DIV_W]     = div_q;
        host_rdata[CFG_NEG]                 = neg_q;
      end
      SEL_CTL: begin
        host_rdata[CTL_READ]                = ctlrd_q;
        host_rdata[2*FIELD_W-1:FIELD_W]     = pa_q;
        host_rdata[FIELD_W-1:0]             = ra_q;
      end
      SEL_DATA: host_rdata[DATA_BITS-1:0]   = data_q;
      default:  host_rdata[DATA_BITS-1:0]   = addr_q;
    endcase
  end

  assign cfg_neg = neg_q;
  assign cfg_div = div_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int               DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(129)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic [3:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  logic                  rst_meta, rst_sync_n;
  logic                  busy, start, start_read;
  logic [FRAME_BITS-1:0] start_frame;
  logic                  cfg_neg;
  logic [DIV_W-1:0]      cfg_div;
  logic                  rise_ev, fall_ev;
  logic                  rd_done, rd_err;
  logic [DATA_BITS-1:0]  rd_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  mdio_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .host_req    (host_req),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .busy        (busy),
    .rd_done     (rd_done),
    .rd_err_in   (rd_err),
    .rd_cap      (rd_data),
    .start       (start),
    .start_read  (start_read),
    .start_frame (start_frame),
    .cfg_neg     (cfg_neg),
    .cfg_div     (cfg_div)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (busy),
    .half    (cfg_div),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start       (start),
    .start_read  (start_read),
    .start_frame (start_frame),
    .neg_mode    (cfg_neg),
    .rise_ev     (rise_ev),
    .fall_ev     (fall_ev),
    .mdio_i      (mdio_i),
    .busy        (busy),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .rd_done     (rd_done),
    .rd_err      (rd_err),
    .rd_data     (rd_data)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             neg_mode,
  input logic [DIV_W-1:0] div,
  input logic             host_req,
  input logic             host_wr
);

  assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  assert_frame_opens_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mdio_oe && mdio_o));

  assert_idle_mdc_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  assert_launch_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o)))
      |-> ((mdc != $past(mdc)) && (mdc == !neg_mode)));

  assert_busy_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_req && host_wr) |=> ($stable(div) && $stable(neg_mode)));

endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .neg_mode (cfg_neg),
  .div      (cfg_div),
  .host_req (host_req),
  .host_wr  (host_wr)
);

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;

  logic        clk;
  logic        rst_n;
  logic        host_req, host_wr;
  logic [3:0]  host_addr;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en, phy_val;

  int tests = 0;
  int fails = 0;

  // PHY model state
  logic [63:0] cap, oe_log;
  int          rise_n;
  logic        phy_respond;
  logic [15:0] phy_data;
  logic        tb_neg;
  int          edge_bad, contention;
  int          cyc, last_rise, last_period;
  logic        mdc_prev, line_prev, oe_prev, o_prev;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

  mdio_master u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // line monitor and PHY responder
  initial begin
    phy_en = 1'b0; phy_val = 1'b1; rise_n = 0; cap = '0; oe_log = '0;
    edge_bad = 0; contention = 0; cyc = 0; last_rise = 0; last_period = 0;
    mdc_prev = 1'b0; line_prev = 1'b1; oe_prev = 1'b0; o_prev = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (mdio_oe && oe_prev && (mdio_o != o_prev)) begin
        if (tb_neg ? !(!mdc && mdc_prev) : !(mdc && !mdc_prev)) edge_bad++;
      end
      if (mdio_oe && phy_en) contention++;
      if (mdc && !mdc_prev) begin
        if (rise_n < 64) begin
          cap[63-rise_n]    = line_prev;
          oe_log[63-rise_n] = oe_prev;
        end
        rise_n++;
        last_period = cyc - last_rise;
        last_rise   = cyc;
        if (phy_respond && cap[63-34] && rise_n >= 47 && rise_n <= 63) begin
          phy_en  = 1'b1;
          phy_val = (rise_n == 47) ? 1'b0 : phy_data[63-rise_n];
        end else begin
          phy_en  = 1'b0;
          phy_val = 1'b1;
        end
      end
      mdc_prev  = mdc;
      line_prev = mdio_i;
      oe_prev   = mdio_oe;
      o_prev    = mdio_o;
    end
  end

  task automatic hwrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h1;
    for (int i = 0; i < 5000 && v[0]; i++) hread(4'h0, v);
    check(!v[0], "R2 busy clears", {63'd0, v[0]}, 64'd0);
  endtask

  function automatic logic [63:0] exp_frame(input bit c45, input int kind,
      input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    if (kind == 0) op = 2'b00;
    else if (kind == 1) op = 2'b01;
    else op = c45 ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, st, op, pa, ra, 2'b10, d};
  endfunction

  // write-type frame started by wr_addr/wr_val and compared in full
  task automatic run_out(input string req, input logic [3:0] a, input logic [31:0] v,
                         input logic [63:0] exp);
    logic [31:0] r;
    rise_n = 0;
    hwrite(a, v);
    hread(4'h0, r);
    check(r[0] == 1'b1, "R2 busy during frame", {63'd0, r[0]}, 64'd1);
    wait_idle();
    check(cap == exp, req, cap, exp);
    check(rise_n == 64, "R2 64 MDC rises", 64'(rise_n), 64'd64);
  endtask

  task automatic run_read(input string req, input logic [31:0] ctl,
                          input logic [63:0] exp, input bit answer, input logic [15:0] d);
    phy_respond = answer;
    phy_data    = d;
    rise_n = 0;
    hwrite(4'h4, ctl);
    wait_idle();
    check(cap[63:18] == exp[63:18], req, {18'd0, cap[63:18]}, {18'd0, exp[63:18]});
    check(oe_log[17:0] == 18'd0, {req, " released"}, {46'd0, oe_log[17:0]}, 64'd0);
    check(contention == 0, {req, " no contention"}, 64'(contention), 64'd0);
    phy_respond = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    hread(4'h0, r); check(r == 32'h0000_8100, "R1 cfg reset", {32'd0, r}, 64'h8100);
    hread(4'h4, r); check(r == 32'h0, "R1 ctl reset", {32'd0, r}, 64'h0);
    hread(4'h8, r); check(r == 32'h0, "R1 data reset", {32'd0, r}, 64'h0);
    hread(4'hC, r); check(r == 32'h0, "R1 addr reset", {32'd0, r}, 64'h0);
    check(!mdc && !mdio_oe, "R1 bus idle", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] r;
    hwrite(4'h0, 32'h0080_0540);
    hread(4'h0, r); check(r == 32'h0080_0540, "R11 cfg readback", {32'd0, r}, 64'h0080_0540);
    hwrite(4'h0, 32'h0000_0100);
    hwrite(4'h4, 32'h0000_03FF);
    hread(4'h4, r); check(r == 32'h0000_03FF, "R11 ctl readback", {32'd0, r}, 64'h3FF);
    hread(4'h0, r); check(r[0] == 1'b0, "R11 no frame without read bit", {63'd0, r[0]}, 64'd0);
  endtask

  task automatic t_c22_write();
    logic [31:0] r;
    tb_neg = 1'b0;
    hwrite(4'h0, 32'h0000_0100);
    hwrite(4'h4, 32'h0000_0153);
    run_out("R3 c22 write frame", 4'h8, 32'h0000_BEEF,
            exp_frame(1'b0, 1, 5'h0A, 5'h13, 16'hBEEF));
    hread(4'h8, r); check(r == 32'h0000_BEEF, "R3 data readback", {32'd0, r}, 64'hBEEF);
    check(edge_bad == 0, "R9 rising-edge launch", 64'(edge_bad), 64'd0);
  endtask

  task automatic t_c22_read();
    logic [31:0] r;
    run_read("R4 c22 read header", 32'h0000_8062,
             exp_frame(1'b0, 2, 5'h03, 5'h02, 16'h0), 1'b1, 16'h1234);
    hread(4'h8, r); check(r == 32'h0000_1234, "R4 captured data", {32'd0, r}, 64'h1234);
    hread(4'h0, r); check(r[1] == 1'b0, "R4 no error", {63'd0, r[1]}, 64'd0);
  endtask

  task automatic t_c45();
    logic [31:0] r;
    hwrite(4'h0, 32'h0000_0140);
    hwrite(4'h4, 32'h0000_0025);
    run_out("R5 c45 address frame", 4'hC, 32'h0000_5A5A,
            exp_frame(1'b1, 0, 5'h01, 5'h05, 16'h5A5A));
    run_out("R6 c45 write frame", 4'h8, 32'h0000_0F0F,
            exp_frame(1'b1, 1, 5'h01, 5'h05, 16'h0F0F));
    run_read("R6 c45 read header", 32'h0000_8025,
             exp_frame(1'b1, 2, 5'h01, 5'h05, 16'h0), 1'b1, 16'hCAFE);
    hread(4'h8, r); check(r == 32'h0000_CAFE, "R6 c45 captured data", {32'd0, r}, 64'hCAFE);
    hwrite(4'h0, 32'h0000_0100);
    rise_n = 0;
    hwrite(4'hC, 32'h0000_1111);
    repeat (20) @(negedge clk);
    hread(4'h0, r); check(r[0] == 1'b0, "R5 c22 address write starts nothing", {63'd0, r[0]}, 64'd0);
    check(rise_n == 0, "R5 no MDC activity", 64'(rise_n), 64'd0);
    hread(4'hC, r); check(r == 32'h0000_1111, "R5 address stored", {32'd0, r}, 64'h1111);
  endtask

  task automatic t_err();
    logic [31:0] r;
    run_read("R7 silent read header", 32'h0000_8041,
             exp_frame(1'b0, 2, 5'h02, 5'h01, 16'h0), 1'b0, 16'h0);
    hread(4'h0, r); check(r[1] == 1'b1, "R7 error set", {63'd0, r[1]}, 64'd1);
    hread(4'h8, r); check(r == 32'h0000_FFFF, "R7 data all ones", {32'd0, r}, 64'hFFFF);
    run_out("R7 write after error", 4'h8, 32'h0000_A5A5,
            exp_frame(1'b0, 1, 5'h02, 5'h01, 16'hA5A5));
    hread(4'h0, r); check(r[1] == 1'b1, "R7 error sticky over write", {63'd0, r[1]}, 64'd1);
    phy_respond = 1'b1; phy_data = 16'h4321; rise_n = 0;
    hwrite(4'h4, 32'h0000_8041);
    hread(4'h0, r);
    check(r[1:0] == 2'b01, "R7 error cleared at read start", {62'd0, r[1:0]}, 64'd1);
    wait_idle();
    phy_respond = 1'b0;
    hread(4'h8, r); check(r == 32'h0000_4321, "R7 good read after error", {32'd0, r}, 64'h4321);
  endtask

  task automatic t_div();
    hwrite(4'h0, 32'h0000_0300);
    run_out("R8 frame at half=3", 4'h8, 32'h0000_0001,
            exp_frame(1'b0, 1, 5'h02, 5'h01, 16'h0001));
    check(last_period == 6, "R8 period half=3", 64'(last_period), 64'd6);
    hwrite(4'h0, 32'h0000_0000);
    run_out("R8 frame at half=0", 4'h8, 32'h0000_8000,
            exp_frame(1'b0, 1, 5'h02, 5'h01, 16'h8000));
    check(last_period == 2, "R8 period half=0", 64'(last_period), 64'd2);
    check(!mdc, "R8 mdc idle low", {63'd0, mdc}, 64'd0);
  endtask

  task automatic t_neg();
    logic [31:0] r;
    hwrite(4'h0, 32'h0080_0100);
    tb_neg = 1'b1;
    edge_bad = 0;
    run_out("R9 falling-edge write frame", 4'h8, 32'h0000_3C3C,
            exp_frame(1'b0, 1, 5'h02, 5'h01, 16'h3C3C));
    run_read("R9 falling-edge read header", 32'h0000_8041,
             exp_frame(1'b0, 2, 5'h02, 5'h01, 16'h0), 1'b1, 16'h9876);
    hread(4'h8, r); check(r == 32'h0000_9876, "R9 falling-edge read data", {32'd0, r}, 64'h9876);
    check(edge_bad == 0, "R9 falling-edge launch", 64'(edge_bad), 64'd0);
    hwrite(4'h0, 32'h0000_0100);
    tb_neg = 1'b0;
  endtask

  task automatic t_busy();
    logic [31:0] r;
    hwrite(4'h4, 32'h0000_0041);
    rise_n = 0;
    hwrite(4'h8, 32'h0000_1357);
    hwrite(4'h8, 32'h0000_2468);
    hwrite(4'h0, 32'h0000_0340);
    hwrite(4'h4, 32'h0000_8000);
    hwrite(4'hC, 32'h0000_7777);
    wait_idle();
    check(cap == exp_frame(1'b0, 1, 5'h02, 5'h01, 16'h1357), "R10 first frame intact",
          cap, exp_frame(1'b0, 1, 5'h02, 5'h01, 16'h1357));
    repeat (300) @(negedge clk);
    check(rise_n == 64, "R10 no second frame", 64'(rise_n), 64'd64);
    hread(4'h8, r); check(r == 32'h0000_1357, "R10 data kept", {32'd0, r}, 64'h1357);
    hread(4'h0, r); check(r == 32'h0000_0100, "R10 cfg kept", {32'd0, r}, 64'h100);
    hread(4'h4, r); check(r == 32'h0000_0041, "R10 ctl kept", {32'd0, r}, 64'h41);
    hread(4'hC, r); check(r == 32'h0000_1111, "R10 addr kept", {32'd0, r}, 64'h1111);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_req = 1'b0; host_wr = 1'b0; host_addr = 4'h0;
    host_wdata = 32'h0; phy_respond = 1'b0; phy_data = 16'h0; tb_neg = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_regs();
    t_c22_write();
    t_c22_read();
    t_c45();
    t_err();
    t_div();
    t_neg();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule